// File: doc/BRIEF.md
# Peripheral Security Access Filter

This block sits between one bus master and a set of downstream peripheral ports. It accepts one transfer at a time on a valid/ready request channel. It judges each transfer against two per-port configuration bits and a fixed bypass mask. Transfers that pass go out unchanged to the chosen port, and that port's response comes back to the master. Transfers that fail never reach a port. They end locally, with either a bus error or a quiet completion (reads return zero, writes are dropped), depending on one policy input.

Every rejected transfer can raise a sticky violation flag. The flag drives an interrupt through an enable gate. A level-sensitive clear input both wipes the flag and, while held high, stops new violations from setting it. Requests that name a port that does not exist, or that carry an illegal size code, end with an error and leave the flag untouched.

Top module: `periph_sec_filter`

## Requirements
- R1: After a synchronous reset the internal copies of the per-port non-secure bits, the per-port unprivileged-access bits and the error-policy bit are 0. The violation flag and `irq_o` are 0, no port is requested, no response is pending and `req_ready_o` is 1.
- R2: A transfer to port p is rejected when its secure attribute equals non-secure bit p. When bit p of the parameter `NONSEC_MASK` is 1, this test is skipped for port p.
- R3: A transfer whose user attribute is 1 is rejected when unprivileged-access bit p is 0, whatever the mask holds.
- R4: A rejected transfer never asserts any `dn_valid_o` bit. Its response carries `rsp_err_o` equal to the error-policy bit and `rsp_rdata_o` equal to 0.
- R5: An accepted transfer asserts exactly `dn_valid_o[p]`, with address, write flag, write data, size, secure and user passed through unchanged. It holds them until `dn_ready_i[p]`, then waits for `dn_rsp_valid_i[p]` and returns `dn_rsp_err_i[p]` and slice p of `dn_rdata_i` (bits p*DATA_W upward) as its response.
- R6: A rejected transfer sets the violation flag at its acceptance edge if `irq_clr_i` is 0 at that edge. The flag stays set until a clear. When a clear and a rejection share an edge, the flag ends up 0.
- R7: At each clock edge where `irq_clr_i` is 1, the violation flag becomes 0.
- R8: `irq_o` is a register that takes (next flag value AND `irq_en_i`) at every edge, so it follows changes in either one a cycle later.
- R9: Size code s on `req_size_i` means 2^s bytes for s from 0 to 3, with data in little-endian lanes. Codes 4 to 7 end with an error response, are not forwarded and leave the flag unchanged.
- R10: A port index of `NPORTS` or above, or a port whose bit in `PORT_PRESENT` is 0, ends with an error response, is not forwarded and leaves the flag unchanged.
- R11: `req_ready_o` is 1 only while idle. A locally ended transfer shows `rsp_valid_o` for exactly one cycle, starting one edge after acceptance. Configuration inputs take effect one edge after they change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Filter idle, request taken this edge |
| req_port_i | input | PIDX_W | Target port index |
| req_addr_i | input | ADDR_W | Transfer address |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data, little-endian lanes |
| req_size_i | input | 3 | Size code, 2^code bytes |
| req_secure_i | input | 1 | Secure attribute |
| req_user_i | input | 1 | Unprivileged attribute |
| rsp_valid_o | output | 1 | One-cycle response strobe |
| rsp_err_o | output | 1 | Response is a bus error |
| rsp_rdata_o | output | DATA_W | Response read data |
| dn_valid_o | output | NPORTS | One-hot downstream request |
| dn_ready_i | input | NPORTS | Downstream accept, per port |
| dn_addr_o | output | ADDR_W | Forwarded address |
| dn_write_o | output | 1 | Forwarded write flag |
| dn_wdata_o | output | DATA_W | Forwarded write data |
| dn_size_o | output | 3 | Forwarded size code |
| dn_secure_o | output | 1 | Forwarded secure attribute |
| dn_user_o | output | 1 | Forwarded user attribute |
| dn_rsp_valid_i | input | NPORTS | Downstream response strobe, per port |
| dn_rsp_err_i | input | NPORTS | Downstream error, per port |
| dn_rdata_i | input | NPORTS*DATA_W | Downstream read data, packed per port |
| cfg_nonsec_i | input | NPORTS | Per-port non-secure bit |
| cfg_unpriv_i | input | NPORTS | Per-port unprivileged-access bit |
| cfg_err_resp_i | input | 1 | 1 = rejected transfers answer with error |
| irq_en_i | input | 1 | Interrupt enable |
| irq_clr_i | input | 1 | Level-sensitive flag clear |
| irq_o | output | 1 | Violation interrupt |

## Verification
The bench builds the filter with 16 ports and a 5-bit port index, so indices 16 to 31 can be driven to exercise the out-of-range path. It sets `NONSEC_MASK` to 16'h00F0, which makes ports 4 to 7 bypass the security test while the privilege test still applies to them. It sets `PORT_PRESENT` to 16'h7FFF, so port 15 is a valid index with no peripheral behind it. A sweep over ports 0 to 17 with every secure/user pairing then reaches each verdict, on both mask settings and both access-bit settings.

// File: rtl/psf_pkg.sv
package psf_pkg;

    localparam int SZ_W = 3;

    typedef enum logic [1:0] {
        V_PASS  = 2'd0,
        V_DENY  = 2'd1,
        V_FAULT = 2'd2
    } verdict_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2,
        ST_DONE  = 2'd3
    } xfer_st_e;

    // Size codes 0..3 stand for 1, 2, 4 and 8 bytes.
    function automatic logic size_ok(input logic [SZ_W-1:0] code);
        return code < SZ_W'(4);
    endfunction

    function automatic logic port_deny(
        input logic sec,
        input logic usr,
        input logic ns_bit,
        input logic ap_bit,
        input logic bypass
    );
        return ((sec == ns_bit) && !bypass) || (usr && !ap_bit);
    endfunction

endpackage

// File: rtl/psf_check.sv
module psf_check
    import psf_pkg::*;
#(
    parameter int                NPORTS       = 16,
    parameter int                PIDX_W       = 5,
    parameter logic [NPORTS-1:0] NONSEC_MASK  = '0,
    parameter logic [NPORTS-1:0] PORT_PRESENT = '1
) (
    input  logic [PIDX_W-1:0] idx_i,
    input  logic [SZ_W-1:0]   size_i,
    input  logic              sec_i,
    input  logic              usr_i,
    input  logic [NPORTS-1:0] ns_i,
    input  logic [NPORTS-1:0] ap_i,
    output verdict_e          verdict_o
);

    logic [NPORTS-1:0] deny_vec;

    for (genvar g = 0; g < NPORTS; g++) begin : g_rule
        assign deny_vec[g] = port_deny(sec_i, usr_i, ns_i[g], ap_i[g], NONSEC_MASK[g]);
    end

    logic hit;
    logic den;

    always_comb begin
        hit = 1'b0;
        den = 1'b0;
        for (int i = 0; i < NPORTS; i++) begin
            if (idx_i == PIDX_W'(i)) begin
                hit = PORT_PRESENT[i];
                den = deny_vec[i];
            end
        end
    end

    always_comb begin
        if (!hit || !size_ok(size_i)) begin
            verdict_o = V_FAULT;
        end else if (den) begin
            verdict_o = V_DENY;
        end else begin
            verdict_o = V_PASS;
        end
    end

endmodule

// File: rtl/psf_irq.sv
module psf_irq (
    input  logic clk,
    input  logic rst,
    input  logic viol_i,
    input  logic clr_i,
    input  logic en_i,
    output logic irq_o
);

    logic stat_q;
    logic stat_d;
    logic irq_q;

    // A held clear both wipes the flag and masks a same-edge violation.
    always_comb begin
        if (clr_i) begin
            stat_d = 1'b0;
        end else if (viol_i) begin
            stat_d = 1'b1;
        end else begin
            stat_d = stat_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            stat_q <= stat_d;
            irq_q  <= stat_d & en_i;
        end
    end

    assign irq_o = irq_q;

    a_r6_sticky_flag: assert property (@(posedge clk) disable iff (rst)
        (stat_q && !clr_i) |=> stat_q);

    a_r7_clear_drops_irq: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> !irq_o);

    a_r8_enable_gates: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> !irq_o);

endmodule

// File: rtl/psf_xfer.sv
module psf_xfer
    import psf_pkg::*;
#(
    parameter int NPORTS = 16,
    parameter int PIDX_W = 5,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic [PIDX_W-1:0]        req_port_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic                     req_write_i,
    input  logic [DATA_W-1:0]        req_wdata_i,
    input  logic [SZ_W-1:0]          req_size_i,
    input  logic                     req_secure_i,
    input  logic                     req_user_i,
    input  verdict_e                 verdict_i,
    input  logic                     err_resp_i,
    output logic                     viol_o,
    output logic [NPORTS-1:0]        dn_valid_o,
    input  logic [NPORTS-1:0]        dn_ready_i,
    output logic [ADDR_W-1:0]        dn_addr_o,
    output logic                     dn_write_o,
    output logic [DATA_W-1:0]        dn_wdata_o,
    output logic [SZ_W-1:0]          dn_size_o,
    output logic                     dn_secure_o,
    output logic                     dn_user_o,
    input  logic [NPORTS-1:0]        dn_rsp_valid_i,
    input  logic [NPORTS-1:0]        dn_rsp_err_i,
    input  logic [NPORTS*DATA_W-1:0] dn_rdata_i,
    output logic                     rsp_valid_o,
    output logic                     rsp_err_o,
    output logic [DATA_W-1:0]        rsp_rdata_o
);

    typedef struct packed {
        logic [PIDX_W-1:0] port;
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [SZ_W-1:0]   size;
        logic              secure;
        logic              user;
    } xreq_t;

    xfer_st_e          st_q;
    xreq_t             cur_q;
    logic              fwd_q;
    logic              rsp_err_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    logic [NPORTS-1:0] sel_oh;
    logic [DATA_W-1:0] rd_slice [NPORTS];
    logic [DATA_W-1:0] rd_sel;

    for (genvar g = 0; g < NPORTS; g++) begin : g_port
        assign sel_oh[g]   = (cur_q.port == PIDX_W'(g));
        assign rd_slice[g] = sel_oh[g] ? dn_rdata_i[g*DATA_W +: DATA_W] : '0;
    end

    always_comb begin
        rd_sel = '0;
        for (int i = 0; i < NPORTS; i++) begin
            rd_sel = rd_sel | rd_slice[i];
        end
    end

    logic acc;
    logic dn_rdy_sel;
    logic dn_rsp_sel;
    logic dn_err_sel;

    assign acc        = req_valid_i && (st_q == ST_IDLE);
    assign dn_rdy_sel = |(dn_ready_i & sel_oh);
    assign dn_rsp_sel = |(dn_rsp_valid_i & sel_oh);
    assign dn_err_sel = |(dn_rsp_err_i & sel_oh);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= ST_IDLE;
            cur_q       <= '0;
            fwd_q       <= 1'b0;
            rsp_err_q   <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (acc) begin
                        cur_q       <= '{port:   req_port_i,
                                         addr:   req_addr_i,
                                         write:  req_write_i,
                                         wdata:  req_wdata_i,
                                         size:   req_size_i,
                                         secure: req_secure_i,
                                         user:   req_user_i};
                        fwd_q       <= (verdict_i == V_PASS);
                        rsp_err_q   <= (verdict_i == V_FAULT) ||
                                       ((verdict_i == V_DENY) && err_resp_i);
                        rsp_rdata_q <= '0;
                        st_q        <= (verdict_i == V_PASS) ? ST_ISSUE : ST_DONE;
                    end
                end
                ST_ISSUE: begin
                    if (dn_rdy_sel) begin
                        st_q <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (dn_rsp_sel) begin
                        rsp_err_q   <= dn_err_sel;
                        rsp_rdata_q <= rd_sel;
                        st_q        <= ST_DONE;
                    end
                end
                default: begin
                    st_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready_o = (st_q == ST_IDLE);
    assign viol_o      = acc && (verdict_i == V_DENY);
    assign dn_valid_o  = (st_q == ST_ISSUE) ? sel_oh : '0;
    assign dn_addr_o   = cur_q.addr;
    assign dn_write_o  = cur_q.write;
    assign dn_wdata_o  = cur_q.wdata;
    assign dn_size_o   = cur_q.size;
    assign dn_secure_o = cur_q.secure;
    assign dn_user_o   = cur_q.user;
    assign rsp_valid_o = (st_q == ST_DONE);
    assign rsp_err_o   = rsp_err_q;
    assign rsp_rdata_o = rsp_rdata_q;

    a_r5_onehot_issue: assert property (@(posedge clk) disable iff (rst)
        $onehot0(dn_valid_o));

    a_r4_reject_local: assert property (@(posedge clk) disable iff (rst)
        (acc && verdict_i != V_PASS) |=> (dn_valid_o == '0 && rsp_valid_o));

    a_r4_reject_zero: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid_o && !fwd_q) |-> (rsp_rdata_o == '0));

    a_r9_size_legal: assert property (@(posedge clk) disable iff (rst)
        (|dn_valid_o) |-> (dn_size_o < SZ_W'(4)));

    a_r11_single_rsp: assert property (@(posedge clk) disable iff (rst)
        rsp_valid_o |=> !rsp_valid_o);

endmodule

// File: rtl/periph_sec_filter.sv
module periph_sec_filter
    import psf_pkg::*;
#(
    parameter int                NPORTS       = 16,
    parameter int                PIDX_W       = $clog2(NPORTS) + 1,
    parameter int                ADDR_W       = 32,
    parameter int                DATA_W       = 64,
    parameter logic [NPORTS-1:0] NONSEC_MASK  = '0,
    parameter logic [NPORTS-1:0] PORT_PRESENT = '1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic [PIDX_W-1:0]        req_port_i,
    input  logic [ADDR_W-1:0]        req_addr_i,
    input  logic                     req_write_i,
    input  logic [DATA_W-1:0]        req_wdata_i,
    input  logic [2:0]               req_size_i,
    input  logic                     req_secure_i,
    input  logic                     req_user_i,
    output logic                     rsp_valid_o,
    output logic                     rsp_err_o,
    output logic [DATA_W-1:0]        rsp_rdata_o,
    output logic [NPORTS-1:0]        dn_valid_o,
    input  logic [NPORTS-1:0]        dn_ready_i,
    output logic [ADDR_W-1:0]        dn_addr_o,
    output logic                     dn_write_o,
    output logic [DATA_W-1:0]        dn_wdata_o,
    output logic [2:0]               dn_size_o,
    output logic                     dn_secure_o,
    output logic                     dn_user_o,
    input  logic [NPORTS-1:0]        dn_rsp_valid_i,
    input  logic [NPORTS-1:0]        dn_rsp_err_i,
    input  logic [NPORTS*DATA_W-1:0] dn_rdata_i,
    input  logic [NPORTS-1:0]        cfg_nonsec_i,
    input  logic [NPORTS-1:0]        cfg_unpriv_i,
    input  logic                     cfg_err_resp_i,
    input  logic                     irq_en_i,
    input  logic                     irq_clr_i,
    output logic                     irq_o
);

    logic [NPORTS-1:0] ns_q;
    logic [NPORTS-1:0] ap_q;
    logic              eresp_q;

    // Configuration copies, cleared by reset, refreshed every cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            ns_q    <= '0;
            ap_q    <= '0;
            eresp_q <= 1'b0;
        end else begin
            ns_q    <= cfg_nonsec_i;
            ap_q    <= cfg_unpriv_i;
            eresp_q <= cfg_err_resp_i;
        end
    end

    verdict_e verdict;
    logic     viol;

    psf_check #(
        .NPORTS       (NPORTS),
        .PIDX_W       (PIDX_W),
        .NONSEC_MASK  (NONSEC_MASK),
        .PORT_PRESENT (PORT_PRESENT)
    ) u_check (
        .idx_i     (req_port_i),
        .size_i    (req_size_i),
        .sec_i     (req_secure_i),
        .usr_i     (req_user_i),
        .ns_i      (ns_q),
        .ap_i      (ap_q),
        .verdict_o (verdict)
    );

    psf_xfer #(
        .NPORTS (NPORTS),
        .PIDX_W (PIDX_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_xfer (
        .clk            (clk),
        .rst            (rst),
        .req_valid_i    (req_valid_i),
        .req_ready_o    (req_ready_o),
        .req_port_i     (req_port_i),
        .req_addr_i     (req_addr_i),
        .req_write_i    (req_write_i),
        .req_wdata_i    (req_wdata_i),
        .req_size_i     (req_size_i),
        .req_secure_i   (req_secure_i),
        .req_user_i     (req_user_i),
        .verdict_i      (verdict),
        .err_resp_i     (eresp_q),
        .viol_o         (viol),
        .dn_valid_o     (dn_valid_o),
        .dn_ready_i     (dn_ready_i),
        .dn_addr_o      (dn_addr_o),
        .dn_write_o     (dn_write_o),
        .dn_wdata_o     (dn_wdata_o),
        .dn_size_o      (dn_size_o),
        .dn_secure_o    (dn_secure_o),
        .dn_user_o      (dn_user_o),
        .dn_rsp_valid_i (dn_rsp_valid_i),
        .dn_rsp_err_i   (dn_rsp_err_i),
        .dn_rdata_i     (dn_rdata_i),
        .rsp_valid_o    (rsp_valid_o),
        .rsp_err_o      (rsp_err_o),
        .rsp_rdata_o    (rsp_rdata_o)
    );

    psf_irq u_irq (
        .clk    (clk),
        .rst    (rst),
        .viol_i (viol),
        .clr_i  (irq_clr_i),
        .en_i   (irq_en_i),
        .irq_o  (irq_o)
    );

    a_r10_fault_quiet: assert property (@(posedge clk) disable iff (rst)
        (req_valid_i && req_ready_o && verdict == V_FAULT) |=> (rsp_valid_o && rsp_err_o));

endmodule

// File: tb/sim_periph_sec_filter.sv
module sim_periph_sec_filter;

    localparam int NP = 16;
    localparam int PW = 5;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam logic [NP-1:0] MASK = 16'h00F0;
    localparam logic [NP-1:0] PRES = 16'h7FFF;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst;
    logic req_valid, req_ready, req_write, req_secure, req_user;
    logic [PW-1:0] req_port;
    logic [AW-1:0] req_addr;
    logic [DW-1:0] req_wdata;
    logic [2:0]    req_size;
    logic rsp_valid, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [NP-1:0] dn_valid, dn_ready, dn_rsp_valid, dn_rsp_err;
    logic [AW-1:0] dn_addr;
    logic          dn_write, dn_secure, dn_user;
    logic [DW-1:0] dn_wdata;
    logic [2:0]    dn_size;
    logic [NP*DW-1:0] dn_rdata;
    logic [NP-1:0] cfg_ns, cfg_ap;
    logic cfg_eresp, irq_en, irq_clr, irq;

    periph_sec_filter #(
        .NPORTS(NP), .PIDX_W(PW), .ADDR_W(AW), .DATA_W(DW),
        .NONSEC_MASK(MASK), .PORT_PRESENT(PRES)
    ) u0 (
        .clk(clk), .rst(rst),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_port_i(req_port),
        .req_addr_i(req_addr), .req_write_i(req_write), .req_wdata_i(req_wdata),
        .req_size_i(req_size), .req_secure_i(req_secure), .req_user_i(req_user),
        .rsp_valid_o(rsp_valid), .rsp_err_o(rsp_err), .rsp_rdata_o(rsp_rdata),
        .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_addr_o(dn_addr),
        .dn_write_o(dn_write), .dn_wdata_o(dn_wdata), .dn_size_o(dn_size),
        .dn_secure_o(dn_secure), .dn_user_o(dn_user),
        .dn_rsp_valid_i(dn_rsp_valid), .dn_rsp_err_i(dn_rsp_err), .dn_rdata_i(dn_rdata),
        .cfg_nonsec_i(cfg_ns), .cfg_unpriv_i(cfg_ap), .cfg_err_resp_i(cfg_eresp),
        .irq_en_i(irq_en), .irq_clr_i(irq_clr), .irq_o(irq)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int seq    = 0;

    task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Behavioural interrupt model, advanced on every rising edge.
    logic ev_viol = 1'b0;
    logic m_stat  = 1'b0;
    logic m_irq   = 1'b0;

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            m_stat = 1'b0;
            m_irq  = 1'b0;
        end else begin
            if (irq_clr)      m_stat = 1'b0;
            else if (ev_viol) m_stat = 1'b1;
            m_irq = m_stat & irq_en;
        end
    end

    always @(negedge clk) begin
        if (!rst) chk(irq === m_irq, "R8/R6 irq per cycle", 64'(irq), 64'(m_irq));
    end

    always @(posedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [DW-1:0] slot(input int p);
        return {32'hCAFE_0000 + 32'(p), 32'h1234_5678 ^ 32'(p * 16'h0101)};
    endfunction

    // 0 = forwarded, 1 = rejected by policy, 2 = error without flag
    function automatic int outcome(input int p, input int sz, input logic sec, input logic usr);
        logic sec_bad, usr_bad;
        if (p >= NP) return 2;
        if (!PRES[p]) return 2;
        if (sz > 3) return 2;
        sec_bad = !MASK[p] && (sec == cfg_ns[p]);
        usr_bad = usr && !cfg_ap[p];
        return (sec_bad || usr_bad) ? 1 : 0;
    endfunction

    task automatic xfer(input int p, input int sz, input logic wr, input logic sec,
                        input logic usr, input logic rerr, input string tag);
        int k;
        logic [AW-1:0] a;
        logic [DW-1:0] w;
        logic e_err;
        k = outcome(p, sz, sec, usr);
        seq++;
        a = 32'h4000_0000 + 32'(seq * 8);
        w = {32'(seq), 32'hBEEF_0000 + 32'(p)};
        @(negedge clk);
        chk(req_ready === 1'b1, {tag, " R11 ready when idle"}, 64'(req_ready), 64'd1);
        req_valid  = 1'b1;
        req_port   = PW'(p);
        req_size   = 3'(sz);
        req_write  = wr;
        req_secure = sec;
        req_user   = usr;
        req_addr   = a;
        req_wdata  = w;
        ev_viol    = (k == 1);
        @(negedge clk);
        req_valid = 1'b0;
        ev_viol   = 1'b0;
        chk(req_ready === 1'b0, {tag, " R11 busy after accept"}, 64'(req_ready), 64'd0);
        if (k == 0) begin
            chk(dn_valid === NP'(1) << p, {tag, " R5 port strobe"}, 64'(dn_valid), 64'(NP'(1) << p));
            chk(dn_addr === a && dn_wdata === w, {tag, " R5 addr/data unchanged"}, dn_wdata, w);
            chk(dn_size === 3'(sz) && dn_write === wr && dn_secure === sec && dn_user === usr,
                {tag, " R5 attributes unchanged"},
                64'({dn_size, dn_write, dn_secure, dn_user}), 64'({3'(sz), wr, sec, usr}));
            chk(rsp_valid === 1'b0, {tag, " R5 no early response"}, 64'(rsp_valid), 64'd0);
            @(negedge clk);
            dn_rsp_valid[p] = 1'b1;
            dn_rsp_err[p]   = rerr;
            @(negedge clk);
            dn_rsp_valid = '0;
            dn_rsp_err   = '0;
            chk(rsp_valid === 1'b1, {tag, " R5 response strobe"}, 64'(rsp_valid), 64'd1);
            chk(rsp_err === rerr, {tag, " R5 returned error"}, 64'(rsp_err), 64'(rerr));
            chk(rsp_rdata === slot(p), {tag, " R5 returned data"}, rsp_rdata, slot(p));
        end else begin
            e_err = (k == 2) ? 1'b1 : cfg_eresp;
            chk(dn_valid === '0, {tag, " R4 not forwarded"}, 64'(dn_valid), 64'd0);
            chk(rsp_valid === 1'b1, {tag, " R11 local response next cycle"}, 64'(rsp_valid), 64'd1);
            chk(rsp_err === e_err, {tag, " R4 response kind"}, 64'(rsp_err), 64'(e_err));
            chk(rsp_rdata === '0, {tag, " R4 zero data"}, rsp_rdata, 64'd0);
        end
        @(negedge clk);
        chk(rsp_valid === 1'b0, {tag, " R11 single-cycle response"}, 64'(rsp_valid), 64'd0);
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk(irq === 1'b0, "R7 clear empties flag", 64'(irq), 64'd0);
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_port = '0; req_addr = '0; req_write = 1'b0;
        req_wdata = '0; req_size = '0; req_secure = 1'b0; req_user = 1'b0;
        dn_ready = '1; dn_rsp_valid = '0; dn_rsp_err = '0;
        for (int p = 0; p < NP; p++) dn_rdata[p*DW +: DW] = slot(p);
        cfg_ns = 16'hFFFF; cfg_ap = 16'hFFFF; cfg_eresp = 1'b1;
        irq_en = 1'b1; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(irq === 1'b0, "R1 irq low after reset", 64'(irq), 64'd0);
        chk(req_ready === 1'b1, "R1 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid === 1'b0 && dn_valid === '0, "R1 nothing pending",
            64'({rsp_valid, dn_valid}), 64'd0);

        cfg_ns = 16'h0202; cfg_ap = 16'h0F0F; cfg_eresp = 1'b0;
        repeat (2) @(negedge clk);

        xfer(0, 3, 1'b0, 1'b1, 1'b0, 1'b0, "R5 secure read port0");
        xfer(0, 2, 1'b1, 1'b0, 1'b0, 1'b0, "R2 nonsecure on secure port");
        chk(irq === 1'b1, "R6 flag raised by rejection", 64'(irq), 64'd1);
        pulse_clear();
        xfer(4, 1, 1'b1, 1'b0, 1'b0, 1'b0, "R2 mask bypass port4");
        xfer(4, 0, 1'b0, 1'b1, 1'b1, 1'b0, "R3 user blocked despite mask");
        xfer(1, 0, 1'b1, 1'b0, 1'b1, 1'b0, "R3 user allowed port1");
        pulse_clear();

        cfg_eresp = 1'b1;
        @(negedge clk);
        xfer(1, 2, 1'b0, 1'b1, 1'b0, 1'b0, "R4 error policy");
        pulse_clear();

        irq_clr = 1'b1;
        xfer(9, 3, 1'b1, 1'b1, 1'b0, 1'b0, "R6 held clear suppresses");
        irq_clr = 1'b0;
        @(negedge clk);
        chk(irq === 1'b0, "R6 held clear kept flag low", 64'(irq), 64'd0);

        xfer(9, 3, 1'b0, 1'b1, 1'b0, 1'b0, "R8 set flag");
        irq_en = 1'b0;
        @(negedge clk);
        chk(irq === 1'b0, "R8 enable low hides flag", 64'(irq), 64'd0);
        irq_en = 1'b1;
        @(negedge clk);
        chk(irq === 1'b1, "R8 enable restores irq", 64'(irq), 64'd1);
        pulse_clear();

        xfer(2, 5, 1'b0, 1'b0, 1'b0, 1'b0, "R9 illegal size on denied port");
        xfer(3, 4, 1'b1, 1'b1, 1'b0, 1'b0, "R9 illegal size");
        chk(irq === 1'b0, "R9 flag untouched", 64'(irq), 64'd0);
        xfer(15, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R10 absent port");
        xfer(20, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R10 index out of range");
        chk(irq === 1'b0, "R10 flag untouched", 64'(irq), 64'd0);
        xfer(9, 0, 1'b1, 1'b0, 1'b0, 1'b1, "R5 downstream error returned");

        cfg_eresp = 1'b0;
        @(negedge clk);
        for (int p = 0; p < 18; p++) begin
            for (int c = 0; c < 4; c++) begin
                xfer(p, c, c[0], c[0], c[1], 1'b0, "R2/R3 sweep");
            end
        end
        pulse_clear();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule